// File: doc/BRIEF.md
# Scroll Address Sequencer

This block owns the 15-bit current video address that a tile renderer walks through while it draws a frame. It responds to three timing strobes: a frame-start pulse, a line-start pulse and a line-end pulse. On a frame-start pulse it copies the temporary (scroll) address as a whole. On a line-end pulse it steps the address down one pixel row. On a line-start pulse it restores the horizontal scroll bits from the temporary address.

The address is laid out, from the least significant bit upwards, as follows:

- bits 4:0 hold the column (coarse X).
- bits 9:5 hold the tile row (coarse Y).
- bits 11:10 hold the nametable select. Bit 10 is the horizontal nametable and bit 11 is the vertical nametable.
- bits 14:12 hold the pixel row inside the tile (fine Y).

The register updates only while background or sprite rendering is enabled. It stays at zero from reset until the first frame-start pulse that arrives while rendering is enabled.

Top module: `scroll_addr_seq`

## Requirements
- R1: After reset `cur_addr_o` is 0. It stays 0, whatever the line strobes do, until a frame-start pulse is sampled while rendering is enabled.
- R2: While `bg_en_i` and `spr_en_i` are both low, no strobe changes `cur_addr_o`.
- R3: With rendering enabled, a frame-start pulse makes `cur_addr_o` equal to `tmp_addr_i` on the next clock edge.
- R4: A line-start pulse copies bits 4:0 and bit 10 from `tmp_addr_i` and keeps bits 9:5, 11 and 14:12 (keep mask 0x7BE0, copy mask 0x041F).
- R5: On a line-end pulse with fine Y below 7, fine Y increases by 1 and every other bit is kept.
- R6: On a line-end pulse with fine Y equal to 7 and coarse Y not 29 and not 31, fine Y becomes 0, coarse Y increases by 1 and the nametable bits are kept. For example, row 30 advances to 31.
- R7: On a line-end pulse with fine Y equal to 7 and coarse Y equal to 29, fine Y and coarse Y become 0 and bit 11 inverts.
- R8: On a line-end pulse with fine Y equal to 7 and coarse Y equal to 31, fine Y and coarse Y become 0 and bit 11 is kept.
- R9: A frame-start pulse takes precedence over line strobes sampled in the same cycle. The result is exactly `tmp_addr_i`.
- R10: When line-end and line-start pulses coincide, the vertical step is applied first and the horizontal copy is applied to its result.
- R11: `coarse_x_o`, `coarse_y_o`, `nt_sel_o` and `fine_y_o` always equal bits 4:0, 9:5, 11:10 and 14:12 of `cur_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle frame-start strobe |
| line_start_i | input | 1 | One-cycle line-start strobe (horizontal reload) |
| line_end_i | input | 1 | One-cycle line-end strobe (vertical step) |
| bg_en_i | input | 1 | Background rendering enable |
| spr_en_i | input | 1 | Sprite rendering enable |
| tmp_addr_i | input | 15 | Temporary scroll address |
| cur_addr_o | output | 15 | Current video address |
| coarse_x_o | output | 5 | Column field of the current address |
| coarse_y_o | output | 5 | Tile row field of the current address |
| nt_sel_o | output | 2 | Nametable select field of the current address |
| fine_y_o | output | 3 | Pixel row field of the current address |

## Verification
The assertions assume the following about the inputs:
- Each strobe is a single-cycle pulse that is sampled only on the clock edge.
- `tmp_addr_i` is stable in the cycle a frame-start or line-start pulse is sampled.

They do not assume that strobes are exclusive. The stimulus changes inputs only on the falling edge and holds each pulse for exactly one cycle. It deliberately makes strobes coincide, to cover the precedence and composition rules. The stimulus places fine Y and coarse Y at 29, 30 and 31 through frame-start loads, so that every wrap branch is entered from a known state.

// File: rtl/scroll_seq_pkg.sv
package scroll_seq_pkg;
  localparam int DEF_CX_W     = 5;
  localparam int DEF_CY_W     = 5;
  localparam int DEF_FY_W     = 3;
  localparam int DEF_LAST_ROW = 29;

  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_FRAME = 2'd1,
    UPD_LINE  = 2'd2
  } upd_kind_e;
endpackage

// File: rtl/scroll_vert_step.sv
module scroll_vert_step #(
  parameter int CX_W     = 5,
  parameter int CY_W     = 5,
  parameter int FY_W     = 3,
  parameter int LAST_ROW = 29,
  localparam int CY_LO   = CX_W,
  localparam int NT_LO   = CX_W + CY_W,
  localparam int FY_LO   = NT_LO + 2,
  localparam int ADDR_W  = FY_LO + FY_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [FY_W-1:0] FY_MAX = '1;
  localparam logic [CY_W-1:0] CY_MAX = '1;
  localparam logic [CY_W-1:0] CY_WRAP = CY_W'(LAST_ROW);

  logic [FY_W-1:0] fy;
  logic [CY_W-1:0] cy;

  assign fy = addr_i[FY_LO +: FY_W];
  assign cy = addr_i[CY_LO +: CY_W];

  always_comb begin
    addr_o = addr_i;
    if (fy != FY_MAX) begin
      addr_o[FY_LO +: FY_W] = fy + FY_W'(1);
    end else begin
      addr_o[FY_LO +: FY_W] = '0;
      if (cy == CY_WRAP) begin
        addr_o[CY_LO +: CY_W] = '0;
        addr_o[NT_LO + 1]     = ~addr_i[NT_LO + 1];
      end else if (cy == CY_MAX) begin
        // rows past the visible area wrap without a nametable change
        addr_o[CY_LO +: CY_W] = '0;
      end else begin
        addr_o[CY_LO +: CY_W] = cy + CY_W'(1);
      end
    end
  end
endmodule

// File: rtl/scroll_horiz_copy.sv
module scroll_horiz_copy #(
  parameter int CX_W    = 5,
  parameter int CY_W    = 5,
  parameter int FY_W    = 3,
  localparam int NT_LO  = CX_W + CY_W,
  localparam int ADDR_W = NT_LO + 2 + FY_W
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] tmp_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] h_mask;

  for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
    if (b < CX_W || b == NT_LO) begin : g_h
      assign h_mask[b] = 1'b1;
    end else begin : g_v
      assign h_mask[b] = 1'b0;
    end
  end

  assign addr_o = (base_i & ~h_mask) | (tmp_i & h_mask);
endmodule

// File: rtl/scroll_addr_seq.sv
module scroll_addr_seq
  import scroll_seq_pkg::*;
#(
  parameter int CX_W     = DEF_CX_W,
  parameter int CY_W     = DEF_CY_W,
  parameter int FY_W     = DEF_FY_W,
  parameter int LAST_ROW = DEF_LAST_ROW,
  localparam int CY_LO   = CX_W,
  localparam int NT_LO   = CX_W + CY_W,
  localparam int FY_LO   = NT_LO + 2,
  localparam int ADDR_W  = FY_LO + FY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              line_start_i,
  input  logic              line_end_i,
  input  logic              bg_en_i,
  input  logic              spr_en_i,
  input  logic [ADDR_W-1:0] tmp_addr_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [CX_W-1:0]   coarse_x_o,
  output logic [CY_W-1:0]   coarse_y_o,
  output logic [1:0]        nt_sel_o,
  output logic [FY_W-1:0]   fine_y_o
);
  logic              render;
  logic              armed_q;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [ADDR_W-1:0] v_addr, step_base, h_addr;
  upd_kind_e         kind;

  assign render = bg_en_i | spr_en_i;

  scroll_vert_step #(
    .CX_W(CX_W), .CY_W(CY_W), .FY_W(FY_W), .LAST_ROW(LAST_ROW)
  ) u_vert (
    .addr_i (cur_q),
    .addr_o (v_addr)
  );

  // vertical step first, horizontal copy on top of it
  assign step_base = line_end_i ? v_addr : cur_q;

  scroll_horiz_copy #(
    .CX_W(CX_W), .CY_W(CY_W), .FY_W(FY_W)
  ) u_horiz (
    .base_i (step_base),
    .tmp_i  (tmp_addr_i),
    .addr_o (h_addr)
  );

  always_comb begin
    if (!render)           kind = UPD_HOLD;
    else if (frame_start_i) kind = UPD_FRAME;
    else if (armed_q)      kind = UPD_LINE;
    else                   kind = UPD_HOLD;
  end

  always_comb begin
    unique case (kind)
      UPD_FRAME: cur_d = tmp_addr_i;
      UPD_LINE:  cur_d = line_start_i ? h_addr : step_base;
      default:   cur_d = cur_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cur_q <= cur_d;
      if (kind == UPD_FRAME) armed_q <= 1'b1;
    end
  end

  assign cur_addr_o = cur_q;
  assign coarse_x_o = cur_q[0 +: CX_W];
  assign coarse_y_o = cur_q[CY_LO +: CY_W];
  assign nt_sel_o   = cur_q[NT_LO +: 2];
  assign fine_y_o   = cur_q[FY_LO +: FY_W];

  localparam logic [FY_W-1:0] FY_TOP  = '1;
  localparam logic [CY_W-1:0] CY_TOP  = '1;
  localparam logic [CY_W-1:0] CY_WRAP = CY_W'(LAST_ROW);

  logic line_go;
  assign line_go = render && armed_q && !frame_start_i;

  p_unarmed_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !(render && frame_start_i)) |=> (cur_addr_o == '0));

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !render |=> $stable(cur_addr_o));

  p_frame_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (render && frame_start_i) |=> (cur_addr_o == $past(tmp_addr_i)));

  p_hcopy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_go && line_start_i) |=>
      (coarse_x_o == $past(tmp_addr_i[0 +: CX_W])) &&
      (cur_addr_o[NT_LO] == $past(tmp_addr_i[NT_LO])));

  p_fine_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_go && line_end_i && fine_y_o != FY_TOP) |=>
      (fine_y_o == $past(fine_y_o) + FY_W'(1)) && (coarse_y_o == $past(coarse_y_o)));

  p_row_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_go && line_end_i && fine_y_o == FY_TOP && coarse_y_o == CY_WRAP) |=>
      (coarse_y_o == '0) && (fine_y_o == '0) && (nt_sel_o[1] != $past(nt_sel_o[1])));

  p_row_over_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_go && line_end_i && fine_y_o == FY_TOP && coarse_y_o == CY_TOP) |=>
      (coarse_y_o == '0) && (nt_sel_o[1] == $past(nt_sel_o[1])));
endmodule

// File: tb/scroll_addr_seq_bench.sv
module scroll_addr_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0, ls = 1'b0, le = 1'b0, bg = 1'b0, spr = 1'b0;
  logic [14:0] tmp = '0;
  logic [14:0] cur;
  logic [4:0]  cx, cy;
  logic [1:0]  nt;
  logic [2:0]  fy;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [14:0] exp_q[$];
  string       tag_q[$];
  logic [14:0] model = '0;
  bit          model_armed = 1'b0;

  always #4 clk = ~clk;

  scroll_addr_seq u_scroll_addr_seq (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .line_start_i(ls),
    .line_end_i(le), .bg_en_i(bg), .spr_en_i(spr), .tmp_addr_i(tmp),
    .cur_addr_o(cur), .coarse_x_o(cx), .coarse_y_o(cy), .nt_sel_o(nt),
    .fine_y_o(fy)
  );

  function automatic logic [14:0] mk(input int f, input int n, input int r, input int c);
    return {f[2:0], n[1:0], r[4:0], c[4:0]};
  endfunction

  function automatic logic [14:0] vstep(input logic [14:0] a);
    logic [14:0] r = a;
    if (a[14:12] != 3'd7) r[14:12] = a[14:12] + 3'd1;
    else begin
      r[14:12] = 3'd0;
      if (a[9:5] == 5'd29) begin r[9:5] = 5'd0; r[11] = ~a[11]; end
      else if (a[9:5] == 5'd31) r[9:5] = 5'd0;
      else r[9:5] = a[9:5] + 5'd1;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected result pushed to scoreboard
  task automatic drive(input string tag, input bit f, input bit s, input bit e,
                       input bit b, input bit p, input logic [14:0] t);
    logic [14:0] nxt;
    @(negedge clk);
    fs = f; ls = s; le = e; bg = b; spr = p; tmp = t;
    nxt = model;
    if (b || p) begin
      if (f) begin nxt = t; model_armed = 1'b1; end
      else if (model_armed) begin
        if (e) nxt = vstep(nxt);
        if (s) nxt = (nxt & 15'h7BE0) | (t & 15'h041F);
      end
    end
    model = nxt;
    exp_q.push_back(nxt);
    tag_q.push_back(tag);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    if (rst_n) begin
      #2;
      if (exp_q.size() > 0) begin
        logic [14:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, cur, e);
        check("R11 fields", {fy, nt, cy, cx}, cur);
      end
    end
  end

  initial begin
    #1_600_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", cur, 15'h0000);
    rst_n = 1'b1;
    // R1: line strobes before any frame start leave zero
    drive("R1 unarmed", 0, 1, 1, 1, 1, 15'h7FFF);
    // R2: frame start with rendering off is ignored
    drive("R2 off frame", 1, 0, 0, 0, 0, 15'h1234);
    // R3: full load
    drive("R3 load", 1, 0, 0, 1, 0, mk(6, 0, 28, 3));
    drive("R5 fine", 0, 0, 1, 1, 0, 15'h0);
    drive("R6 row", 0, 0, 1, 1, 0, 15'h0);
    for (int i = 0; i < 7; i++) drive("R5 fine run", 0, 0, 1, 1, 0, 15'h0);
    drive("R7 wrap29", 0, 0, 1, 1, 0, 15'h0);
    // R8: row 31 wraps without nametable change (sprite enable only)
    drive("R3 load spr", 1, 0, 0, 0, 1, mk(7, 1, 31, 9));
    drive("R8 wrap31", 0, 0, 1, 0, 1, 15'h0);
    // R6: row 30 advances to 31
    drive("R3 load", 1, 0, 0, 1, 1, mk(7, 0, 30, 0));
    drive("R6 row30", 0, 0, 1, 1, 1, 15'h0);
    // R4: horizontal copy
    drive("R4 hcopy", 0, 1, 0, 1, 0, mk(0, 3, 5, 21));
    drive("R4 hcopy2", 0, 1, 0, 1, 0, mk(5, 0, 17, 2));
    // R2: strobes with rendering off
    drive("R2 off line", 0, 1, 1, 0, 0, 15'h7FFF);
    drive("R2 off frame2", 1, 1, 1, 0, 0, 15'h0ABC);
    // R9: frame start wins
    drive("R9 precedence", 1, 1, 1, 1, 0, mk(7, 2, 29, 31));
    // R10: both line strobes, including a wrap at row 29
    drive("R10 combo", 0, 1, 1, 1, 0, mk(3, 1, 12, 7));
    drive("R10 combo2", 0, 1, 1, 0, 1, mk(0, 0, 0, 30));
    drive("R7 hold", 0, 0, 0, 1, 0, 15'h0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule